// File: doc/BRIEF.md
# Channel Address Interleave Reducer

This block turns a system physical address into the address seen by one memory channel. A request carries the address, a controller index and a channel index. The block searches the eight target ranges programmed for that controller. In the first range that holds the address, it subtracts the channel's offset. It then removes the socket interleave and the channel interleave, giving a dense address local to the channel.

Each controller has its own range tables. For each range there is a base word, a wayness word, and one offset word per channel. Software or an earlier stage loads these words through a single register write port. Requests enter on a valid/ready handshake. The response holds the reduced address, the socket way count, the channel way count and a fail flag, and it leaves on a second valid/ready handshake. Each interleave reduction uses a shared restoring divider, which takes a fixed number of cycles. The block handles one request at a time.

Top module: `ch_ilv_reducer`

## Requirements
- R1: After reset every table word is zero. The request side is ready and no response is pending. With all words zero, range 0 covers addresses 0 to 2^26-1 with one socket way and one channel way, so such an address comes back unchanged.
- R2: Range i starts at base word bits [31:12] shifted left by 26. It ends at wayness word bits [31:12] shifted left by 26, with the low 26 bits set. Both ends are included. When several ranges hold the address, the lowest index wins.
- R3: If no range of the selected controller holds the address, the response has the fail flag set to 1.
- R4: Base word bits [5:4] give the socket granularity code, and bits [7:6] give the channel granularity code. Codes 0, 1, 2 and 3 select interleave bits 6, 8, 12 and 30.
- R5: The socket way count is 1 shifted left by wayness bits [11:10], so it is 1, 2, 4 or 8. The channel way count is wayness bits [9:8] plus one, so it is 1 to 4. Both counts are reported with the response.
- R6: Before any reduction, the block subtracts the offset word of the requested channel and range. The offset is bits [23:4] shifted left by 26. The result is taken modulo 2^46.
- R7: One reduction step on value x with bit g and count w gives ((x >> g) / w) << g, ORed with the low g bits of a chosen source. In the default order the socket step runs first and the channel step second, and both take their low bits from the original system address.
- R8: If the channel way count is 3 and the socket bit is strictly above the channel bit, the channel step runs first and the socket step second. Each of these steps takes its low bits from the running value, which starts as the address minus the offset.
- R9: The block accepts a request only when it is idle. After it accepts one, request ready goes low until the response has been taken. A response stays valid, with stable contents, until the response side is ready.
- R10: Write kind 0 loads a base word, kind 1 a wayness word, and kind 2 the offset word of the given channel. Each write goes to the given controller and range index. Kind 3 changes nothing.
- R11: Each controller has its own tables. A request uses only the tables of the controller it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_kind_i | input | 2 | Write kind: 0 base, 1 wayness, 2 offset, 3 none |
| wr_ctrl_i | input | 1 | Controller written |
| wr_chan_i | input | 2 | Channel written (offset kind only) |
| wr_idx_i | input | 3 | Range index written |
| wr_data_i | input | 32 | Table word |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high |
| req_addr_i | input | 46 | System address |
| req_ctrl_i | input | 1 | Controller index |
| req_chan_i | input | 2 | Channel index |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken when high |
| rsp_addr_o | output | 46 | Channel-local address |
| rsp_skt_ways_o | output | 4 | Socket way count |
| rsp_chn_ways_o | output | 3 | Channel way count |
| rsp_fail_o | output | 1 | No range matched |

## Verification
The bench tests both ends of each range, plus the addresses just outside them. A comparison with the wrong sense either drops the limit address or accepts the address one below the base, and the fail flag or the result comes out wrong. Two ranges overlap, so a design that chose the last matching range would report the second range's way counts. The bench uses three-way channel interleave with the socket bit above, equal to and below the channel bit. A design that swapped the order of the steps, or took the low bits from the wrong source, would give a different channel address. The remaining cases are these: a non-zero channel offset, a second controller, an ignored write kind, and a response held back for several cycles. They catch table cross-talk, a write kind that is wrongly decoded, and a response that changes before it is taken.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int UNIT_SH = 26;

  typedef enum logic [1:0] {
    WR_BASE = 2'd0,
    WR_WAY  = 2'd1,
    WR_OFF  = 2'd2,
    WR_NONE = 2'd3
  } wr_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_GO, S_WAIT, S_DONE
  } red_state_e;

  function automatic logic [4:0] gran_bit(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd6;
      2'd1:    return 5'd8;
      2'd2:    return 5'd12;
      default: return 5'd30;
    endcase
  endfunction
endpackage

// File: rtl/ilv_tables.sv
module ilv_tables import ilv_pkg::*; #(
  parameter int N_CTRL = 2,
  parameter int N_CHAN = 3,
  parameter int N_ENT  = 8,
  localparam int CW = (N_CTRL > 1) ? $clog2(N_CTRL) : 1,
  localparam int HW = (N_CHAN > 1) ? $clog2(N_CHAN) : 1,
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [1:0]                wr_kind_i,
  input  logic [CW-1:0]             wr_ctrl_i,
  input  logic [HW-1:0]             wr_chan_i,
  input  logic [IW-1:0]             wr_idx_i,
  input  logic [31:0]               wr_data_i,
  input  logic [CW-1:0]             rd_ctrl_i,
  input  logic [HW-1:0]             rd_chan_i,
  output logic [N_ENT-1:0][31:0]    base_o,
  output logic [N_ENT-1:0][31:0]    way_o,
  output logic [N_ENT-1:0][31:0]    off_o
);
  logic [N_CTRL-1:0][N_ENT-1:0][31:0]             base_q;
  logic [N_CTRL-1:0][N_ENT-1:0][31:0]             way_q;
  logic [N_CTRL-1:0][N_CHAN-1:0][N_ENT-1:0][31:0] off_q;

  logic wr_ok;
  assign wr_ok = wr_en_i && (32'(wr_ctrl_i) < N_CTRL) && (32'(wr_idx_i) < N_ENT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      way_q  <= '0;
      off_q  <= '0;
    end else if (wr_ok) begin
      case (wr_kind_e'(wr_kind_i))
        WR_BASE: base_q[wr_ctrl_i][wr_idx_i] <= wr_data_i;
        WR_WAY:  way_q[wr_ctrl_i][wr_idx_i]  <= wr_data_i;
        WR_OFF:  if (32'(wr_chan_i) < N_CHAN) off_q[wr_ctrl_i][wr_chan_i][wr_idx_i] <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    base_o = '0;
    way_o  = '0;
    off_o  = '0;
    if (32'(rd_ctrl_i) < N_CTRL) begin
      base_o = base_q[rd_ctrl_i];
      way_o  = way_q[rd_ctrl_i];
      if (32'(rd_chan_i) < N_CHAN) off_o = off_q[rd_ctrl_i][rd_chan_i];
    end
  end
endmodule

// File: rtl/ilv_div.sv
module ilv_div #(
  parameter int AW = 46,
  parameter int DW = 4,
  localparam int CNTW = $clog2(AW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic          done_o,
  output logic [AW-1:0] quot_o
);
  logic            busy_q, done_q;
  logic [CNTW-1:0] cnt_q;
  logic [AW-1:0]   q_q;
  logic [DW-1:0]   rem_q, dvs_q;
  logic [DW:0]     rem_sh, rem_nx;
  logic            ge;

  assign rem_sh = {rem_q, q_q[AW-1]};
  assign ge     = rem_sh >= {1'b0, dvs_q};
  assign rem_nx = ge ? rem_sh - {1'b0, dvs_q} : rem_sh;

  // remainder stays below the divisor, so its top bit is always zero
  logic unused_rem;
  assign unused_rem = rem_nx[DW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      q_q    <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNTW'(AW);
        q_q    <= dividend_i;
        rem_q  <= '0;
        dvs_q  <= divisor_i;
      end else if (busy_q) begin
        q_q   <= {q_q[AW-2:0], ge};
        rem_q <= rem_nx[DW-1:0];
        cnt_q <= cnt_q - CNTW'(1);
        if (cnt_q == CNTW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = q_q;
endmodule

// File: rtl/ch_ilv_reducer.sv
module ch_ilv_reducer import ilv_pkg::*; #(
  parameter int AW     = 46,
  parameter int N_CTRL = 2,
  parameter int N_CHAN = 3,
  parameter int N_ENT  = 8,
  localparam int CW = (N_CTRL > 1) ? $clog2(N_CTRL) : 1,
  localparam int HW = (N_CHAN > 1) ? $clog2(N_CHAN) : 1,
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_kind_i,
  input  logic [CW-1:0] wr_ctrl_i,
  input  logic [HW-1:0] wr_chan_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [31:0]   wr_data_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [CW-1:0] req_ctrl_i,
  input  logic [HW-1:0] req_chan_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [AW-1:0] rsp_addr_o,
  output logic [3:0]    rsp_skt_ways_o,
  output logic [2:0]    rsp_chn_ways_o,
  output logic          rsp_fail_o
);
  red_state_e state_q;
  logic [AW-1:0] addr_q, run_q;
  logic [CW-1:0] ctrl_q;
  logic [HW-1:0] chan_q;
  logic [4:0]    sg_q, cg_q;
  logic [3:0]    sw_q;
  logic [2:0]    cw_q;
  logic          chfirst_q, step_q, fail_q;

  logic [N_ENT-1:0][31:0] tb_base, tb_way, tb_off;

  ilv_tables #(.N_CTRL(N_CTRL), .N_CHAN(N_CHAN), .N_ENT(N_ENT)) u_tables (
    .clk_i, .rst_ni, .wr_en_i, .wr_kind_i, .wr_ctrl_i, .wr_chan_i, .wr_idx_i, .wr_data_i,
    .rd_ctrl_i(ctrl_q), .rd_chan_i(chan_q),
    .base_o(tb_base), .way_o(tb_way), .off_o(tb_off)
  );

  // range search, lowest index wins
  logic          hit;
  logic [IW-1:0] hit_idx;
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (addr_q >= AW'({tb_base[i][31:12], {UNIT_SH{1'b0}}}) &&
          addr_q <= AW'({tb_way[i][31:12], {UNIT_SH{1'b1}}})) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  logic [31:0]   sel_base, sel_way, sel_off;
  logic [4:0]    sg_n, cg_n;
  logic [3:0]    sw_n;
  logic [2:0]    cw_n;
  logic [AW-1:0] off_n;
  assign sel_base = tb_base[hit_idx];
  assign sel_way  = tb_way[hit_idx];
  assign sel_off  = tb_off[hit_idx];
  assign sg_n     = gran_bit(sel_base[5:4]);
  assign cg_n     = gran_bit(sel_base[7:6]);
  assign sw_n     = 4'd1 << sel_way[11:10];
  assign cw_n     = 3'(sel_way[9:8]) + 3'd1;
  assign off_n    = AW'({sel_off[23:4], {UNIT_SH{1'b0}}});

  logic unused_bits;
  assign unused_bits = ^{sel_base[11:8], sel_base[3:0], sel_way[7:0], sel_off[31:24], sel_off[3:0]};

  // active step parameters
  logic          use_chan;
  logic [4:0]    cur_g;
  logic [DW-1:0] cur_w;
  logic [AW-1:0] low_src, low_mask, div_q;
  logic          div_done;
  assign use_chan = step_q ? !chfirst_q : chfirst_q;
  assign cur_g    = use_chan ? cg_q : sg_q;
  assign cur_w    = use_chan ? DW'(cw_q) : DW'(sw_q);
  assign low_src  = chfirst_q ? run_q : addr_q;
  assign low_mask = (AW'(1) << cur_g) - AW'(1);

  ilv_div #(.AW(AW), .DW(DW)) u_div (
    .clk_i, .rst_ni,
    .start_i(state_q == S_GO),
    .dividend_i(run_q >> cur_g),
    .divisor_i(cur_w),
    .done_o(div_done),
    .quot_o(div_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      addr_q    <= '0;
      run_q     <= '0;
      ctrl_q    <= '0;
      chan_q    <= '0;
      sg_q      <= '0;
      cg_q      <= '0;
      sw_q      <= 4'd1;
      cw_q      <= 3'd1;
      chfirst_q <= 1'b0;
      step_q    <= 1'b0;
      fail_q    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          ctrl_q  <= req_ctrl_i;
          chan_q  <= req_chan_i;
          state_q <= S_LOOK;
        end
        S_LOOK: begin
          step_q <= 1'b0;
          if (hit) begin
            fail_q    <= 1'b0;
            sg_q      <= sg_n;
            cg_q      <= cg_n;
            sw_q      <= sw_n;
            cw_q      <= cw_n;
            chfirst_q <= (cw_n == 3'd3) && (sg_n > cg_n);
            run_q     <= addr_q - off_n;
            state_q   <= S_GO;
          end else begin
            fail_q  <= 1'b1;
            run_q   <= '0;
            state_q <= S_DONE;
          end
        end
        S_GO: state_q <= S_WAIT;
        S_WAIT: if (div_done) begin
          run_q <= (div_q << cur_g) | (low_src & low_mask);
          if (step_q) state_q <= S_DONE;
          else begin
            step_q  <= 1'b1;
            state_q <= S_GO;
          end
        end
        S_DONE: if (rsp_ready_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o    = state_q == S_IDLE;
  assign rsp_valid_o    = state_q == S_DONE;
  assign rsp_addr_o     = run_q;
  assign rsp_skt_ways_o = sw_q;
  assign rsp_chn_ways_o = cw_q;
  assign rsp_fail_o     = fail_q;
endmodule

// File: rtl/ch_ilv_reducer_chk.sv
module ch_ilv_reducer_chk #(
  parameter int AW = 46
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic          rsp_ready_i,
  input logic [AW-1:0] rsp_addr_o,
  input logic [3:0]    rsp_skt_ways_o,
  input logic [2:0]    rsp_chn_ways_o,
  input logic          rsp_fail_o
);
  // R9
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_addr_o) && $stable(rsp_fail_o));

  // R9
  busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && rsp_valid_o));

  // R9
  accept_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  // R9
  rsp_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ready_i |=> !rsp_valid_o);

  // R5
  skt_ways_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fail_o |-> $countones(rsp_skt_ways_o) == 1);

  // R5
  chn_ways_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fail_o |-> rsp_chn_ways_o >= 3'd1 && rsp_chn_ways_o <= 3'd4);
endmodule

bind ch_ilv_reducer ch_ilv_reducer_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
  .rsp_addr_o(rsp_addr_o), .rsp_skt_ways_o(rsp_skt_ways_o),
  .rsp_chn_ways_o(rsp_chn_ways_o), .rsp_fail_o(rsp_fail_o)
);

// File: tb/sim_ch_ilv_reducer.sv
`timescale 1ns/1ps
module sim_ch_ilv_reducer;
  localparam int AW = 46;
  localparam logic [63:0] AMASK = (64'd1 << AW) - 64'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          wr_en = 1'b0;
  logic [1:0]    wr_kind = '0;
  logic [0:0]    wr_ctrl = '0;
  logic [1:0]    wr_chan = '0;
  logic [2:0]    wr_idx = '0;
  logic [31:0]   wr_data = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [0:0]    req_ctrl = '0;
  logic [1:0]    req_chan = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [AW-1:0] rsp_addr;
  logic [3:0]    rsp_skt;
  logic [2:0]    rsp_chn;
  logic          rsp_fail;

  ch_ilv_reducer u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_kind_i(wr_kind), .wr_ctrl_i(wr_ctrl), .wr_chan_i(wr_chan),
    .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_ctrl_i(req_ctrl), .req_chan_i(req_chan),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_addr_o(rsp_addr),
    .rsp_skt_ways_o(rsp_skt), .rsp_chn_ways_o(rsp_chn), .rsp_fail_o(rsp_fail)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] sb_base [2][8];
  logic [31:0] sb_way  [2][8];
  logic [31:0] sb_off  [2][3][8];

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int gb(input logic [1:0] c);
    case (c)
      2'd0: return 6;
      2'd1: return 8;
      2'd2: return 12;
      default: return 30;
    endcase
  endfunction

  function automatic logic [63:0] red(input logic [63:0] x, input int g, input int w, input logic [63:0] l);
    return ((((x >> g) / w) << g) | (l & ((64'd1 << g) - 64'd1))) & AMASK;
  endfunction

  task automatic model(input logic [63:0] a, input int c, input int ch,
                       output logic [63:0] ea, output int es, output int ec, output bit ef);
    int hit = -1;
    ea = 0; es = 1; ec = 1; ef = 1;
    for (int i = 0; i < 8; i++) begin
      logic [63:0] lo, hi;
      lo = 64'(sb_base[c][i][31:12]) << 26;
      hi = (64'(sb_way[c][i][31:12]) << 26) | 64'h3FF_FFFF;
      if (hit < 0 && a >= lo && a <= hi) hit = i;
    end
    if (hit >= 0) begin
      int sg, cg;
      logic [63:0] ca, r;
      ef = 0;
      sg = gb(sb_base[c][hit][5:4]);
      cg = gb(sb_base[c][hit][7:6]);
      es = 1 << sb_way[c][hit][11:10];
      ec = int'(sb_way[c][hit][9:8]) + 1;
      ca = (a - (64'(sb_off[c][ch][hit][23:4]) << 26)) & AMASK;
      if (ec == 3 && sg > cg) begin
        r = red(ca, cg, ec, ca);
        r = red(r, sg, es, r);
      end else begin
        r = red(ca, sg, es, a);
        r = red(r, cg, ec, a);
      end
      ea = r;
    end
  endtask

  task automatic wr(input int kind, input int c, input int ch, input int i, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 2'(kind); wr_ctrl = 1'(c); wr_chan = 2'(ch); wr_idx = 3'(i); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (kind)
      0: sb_base[c][i] = d;
      1: sb_way[c][i] = d;
      2: sb_off[c][ch][i] = d;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] bw(input int u, input int sg, input int cg);
    return (32'(u) << 12) | (32'(cg) << 6) | (32'(sg) << 4);
  endfunction
  function automatic logic [31:0] ww(input int u, input int sk, input int cn);
    return (32'(u) << 12) | (32'(sk) << 10) | (32'(cn) << 8);
  endfunction

  task automatic xfer(input logic [63:0] a, input int c, input int ch, input int hold, input string req);
    logic [63:0] ea; int es, ec; bit ef;
    int t;
    model(a, c, ch, ea, es, ec, ef);
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(a); req_ctrl = 1'(c); req_chan = 2'(ch);
    t = 0;
    while (!req_ready && t < 1000) begin @(negedge clk); t++; end
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "ready low while busy", 64'(req_ready), 64'd0);
    t = 0;
    while (!rsp_valid && t < 1000) begin @(negedge clk); t++; end
    if (!rsp_valid) begin
      chk(req, "response timeout", 64'd0, 64'd1);
      return;
    end
    if (hold > 0) begin
      logic [AW-1:0] a0;
      bit ok = 1;
      a0 = rsp_addr;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        if (!rsp_valid || rsp_addr !== a0) ok = 0;
      end
      chk("R9", "response held while not ready", 64'(ok), 64'd1);
    end
    chk(req, "fail flag", 64'(rsp_fail), 64'(ef));
    if (!ef) begin
      chk(req, "channel address", 64'(rsp_addr), ea);
      chk(req, "socket ways", 64'(rsp_skt), 64'(es));
      chk(req, "channel ways", 64'(rsp_chn), 64'(ec));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R9", "response released", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1", "request ready after reset", 64'(req_ready), 64'd1);
    chk("R1", "no response after reset", 64'(rsp_valid), 64'd0);
    xfer(64'h123456, 0, 0, 0, "R1");
    xfer(64'h3FF_FFFF, 1, 2, 0, "R1 R2");
    xfer(64'h400_0000, 0, 0, 0, "R3");
  endtask

  task automatic t_program;
    wr(0, 0, 0, 0, bw(32'h3FF, 0, 0)); wr(1, 0, 0, 0, ww(0, 0, 0));
    wr(0, 0, 0, 1, bw(1, 0, 1));       wr(1, 0, 0, 1, ww(3, 1, 2));
    wr(0, 0, 0, 2, bw(4, 2, 1));       wr(1, 0, 0, 2, ww(7, 1, 2));
    wr(0, 0, 0, 3, bw(4, 3, 0));       wr(1, 0, 0, 3, ww(32'hF, 3, 3));
    wr(0, 0, 0, 4, bw(32'h10, 1, 1));  wr(1, 0, 0, 4, ww(32'h1F, 0, 2));
    wr(0, 0, 0, 5, bw(32'h40, 2, 3));  wr(1, 0, 0, 5, ww(32'h7F, 2, 0));
    wr(0, 0, 0, 6, bw(32'h3FF, 0, 0)); wr(0, 0, 0, 7, bw(32'h3FF, 0, 0));
    wr(2, 0, 1, 1, 32'd1 << 4);        wr(2, 0, 1, 2, 32'd2 << 4);
  endtask

  task automatic t_bounds;
    xfer(64'h400_0000, 0, 0, 0, "R2 base");
    xfer(64'hFFF_FFFF, 0, 0, 0, "R2 limit");
    xfer(64'h3FF_FFFF, 0, 0, 0, "R3 below base");
    xfer(64'h1000_0000, 0, 0, 0, "R2 priority");
    xfer(64'h1FFF_FFFF, 0, 0, 0, "R2 priority limit");
    xfer(64'h2000_0000, 0, 0, 0, "R2 next range");
    xfer(64'h8000_0000, 0, 0, 0, "R3 gap");
  endtask

  task automatic t_socket_first;
    xfer(64'h0ABC_DEF1, 0, 0, 0, "R7 R4");
    xfer(64'h2F0F_0F0F, 0, 0, 0, "R7 R4 R5");
    xfer(64'h3FFF_FFFF, 0, 0, 0, "R7 R5");
    xfer(64'h6789_ABCD, 0, 0, 0, "R7 equal bits");
    xfer(64'h1_2345_6789, 0, 0, 0, "R7 R4");
  endtask

  task automatic t_channel_first;
    xfer(64'h1234_5678, 0, 0, 0, "R8");
    xfer(64'h1ABC_DEF7, 0, 2, 0, "R8");
  endtask

  task automatic t_offset;
    xfer(64'h0ABC_DEF1, 0, 1, 0, "R6");
    xfer(64'h1234_5678, 0, 1, 0, "R6 R8");
    xfer(64'h400_0000, 0, 1, 0, "R6 base");
  endtask

  task automatic t_ctrl;
    wr(0, 1, 0, 0, bw(0, 1, 2)); wr(1, 1, 0, 0, ww(32'h3F, 2, 1));
    xfer(64'h0ABC_DEF1, 1, 0, 0, "R11");
    xfer(64'h0ABC_DEF1, 0, 0, 0, "R11");
  endtask

  task automatic t_ignored;
    wr(3, 0, 1, 1, 32'hFFFF_FFFF);
    xfer(64'h0ABC_DEF1, 0, 1, 0, "R10 kind 3");
    xfer(64'h5000_0000, 0, 0, 0, "R10 kind 3");
  endtask

  task automatic t_hold;
    xfer(64'h0777_7777, 0, 0, 6, "R9");
  endtask

  initial begin
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 8; i++) begin
        sb_base[c][i] = '0; sb_way[c][i] = '0;
        for (int h = 0; h < 3; h++) sb_off[c][h][i] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_program;
    t_bounds;
    t_socket_first;
    t_channel_first;
    t_offset;
    t_ctrl;
    t_ignored;
    t_hold;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule